// File: doc/BRIEF.md
# UART Receive Line Status Core

This block produces the eight-bit line status word of a UART with a receive FIFO. The receive shifter presents each finished character with a one-cycle completion strobe. The strobe comes with three indications: a parity fault, a missing stop bit, and a break. The block decides whether the character is stored. It keeps the character in a parameterised receive queue (16 entries by default), and it attaches three error tags to each stored entry. The status word reports the tags of the oldest entry, which is the one the CPU will read next.

The block tracks overrun, and it holds off new characters after a break until the line returns to the idle (mark) level. A counter of errored entries still in the queue drives a summary error bit. The CPU clears that bit by reading the status word, and the bit sets again on the next cycle if errored entries remain. With the FIFO disabled, the queue acts as a single holding register. The two transmit-side bits are formed from the transmit empty inputs.

Top module: `uart_lsr_core`

## Requirements
- R1: `lsr[0]` is 1 exactly when at least one character is stored. A character accepted on a `rx_done` cycle is visible from the following cycle, and it is 0 after reset.
- R2: With `fifo_en`=1, a character that completes while the queue holds DEPTH entries is dropped, unless a read pop happens in the same cycle. The stored count stays the same, and `lsr[1]` reads 1 from the next cycle.
- R3: With `fifo_en`=0, the queue holds at most one character. A character that completes while `lsr[0]` is 1 is dropped and sets `lsr[1]`, and the stored character stays readable.
- R4: `lsr[1]` clears on the cycle after a one-cycle `lsr_rd` strobe. If a new overrun happens in the same cycle as the strobe, `lsr[1]` stays 1.
- R5: `lsr[2]` (parity) and `lsr[3]` (stop bit) give the tags of the oldest stored entry. They are 0 when nothing is stored, and they change when `rhr_pop` removes that entry.
- R6: A completed character flagged as break stores one entry with data 0x00 and its break tag set, and `lsr[4]` shows that tag when the entry is oldest. Later `rx_done` strobes are ignored, storing nothing and raising no overrun, until `rx_line` has been seen at 1 on a clock edge.
- R7: `lsr[5]` equals `thr_empty`, and `lsr[6]` is `thr_empty` AND `tsr_empty`.
- R8: `lsr[7]` is 1 while any stored entry carries a parity, stop-bit or break tag. It reads 0 on the cycle after `lsr_rd`, reads 1 again one cycle later if errored entries remain, and reads 0 once every errored entry has been popped.
- R9: `rhr_data` is the data of the oldest stored entry, and `rhr_pop` removes it. A pop while nothing is stored has no effect on the contents or the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1: queue of DEPTH entries, 0: single holding register |
| rx_done | input | 1 | One-cycle strobe, a received character is complete |
| rx_char | input | 8 | Received character |
| rx_perr | input | 1 | Parity fault of the completed character |
| rx_ferr | input | 1 | Stop-bit fault of the completed character |
| rx_brk | input | 1 | Completed character was a break |
| rx_line | input | 1 | Current receive line level, 1 = mark |
| rhr_pop | input | 1 | CPU reads the oldest character |
| lsr_rd | input | 1 | CPU reads the status word |
| thr_empty | input | 1 | Transmit holding register or FIFO is empty |
| tsr_empty | input | 1 | Transmit shift register is empty |
| lsr | output | 8 | Line status word |
| rhr_data | output | 8 | Data of the oldest stored character |

## Verification
The hardest case to reach is an overrun that coincides with a status read. It needs a queue filled to exactly DEPTH entries with no pop pending, and then a completion strobe and `lsr_rd` in the same cycle. The bench fills the queue through its driver task, uses a reference count to confirm the full state, and then issues both strobes together. It then drains all sixteen entries against the scoreboard, which shows that neither dropped character got in. The break hold is reached by keeping `rx_line` low across a break and a following strobe before the line is released.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              brk;
    } rx_ent_t;
endpackage

// File: rtl/lsr_rx_fifo.sv
module lsr_rx_fifo
    import lsr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  rx_ent_t                      push_ent,
    input  logic                         pop,
    output logic                         pop_ok,
    output rx_ent_t                      top_ent,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    typedef struct packed {
        rx_ent_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]    wp;
        logic [PTR_W-1:0]    rp;
        logic [CNT_W-1:0]    cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        s_d    = s_q;
        pop_ok = pop && (s_q.cnt != '0);
        if (push) begin
            s_d.mem[s_q.wp] = push_ent;
            s_d.wp          = step(s_q.wp);
        end
        if (pop_ok) begin
            s_d.rp = step(s_q.rp);
        end
        case ({push, pop_ok})
            2'b10:   s_d.cnt = s_q.cnt + CNT_W'(1);
            2'b01:   s_d.cnt = s_q.cnt - CNT_W'(1);
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign top_ent = s_q.mem[s_q.rp];
    assign count   = s_q.cnt;

    // R2: storage never accepts a write beyond its capacity
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> ((s_q.cnt < CNT_W'(DEPTH)) || pop_ok));

    // R9: the count never exceeds the storage depth
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(DEPTH));
endmodule

// File: rtl/lsr_push_ctl.sv
module lsr_push_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_done,
    input  logic rx_brk,
    input  logic rx_line,
    input  logic full,
    input  logic pop_ok,
    output logic push,
    output logic ovr_evt,
    output logic brk_hold
);
    typedef struct packed {
        logic hold;
    } ctl_st_t;

    ctl_st_t s_d, s_q;
    logic    take;
    logic    room;

    always_comb begin
        s_d     = s_q;
        take    = rx_done && !s_q.hold;
        room    = !full || pop_ok;
        push    = take && room;
        ovr_evt = take && !room;
        if (s_q.hold && rx_line) s_d.hold = 1'b0;
        if (take && rx_brk)      s_d.hold = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign brk_hold = s_q.hold;

    // R6: a break always leaves the block holding off further characters
    p_brk_enters_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_brk && !brk_hold) |=> brk_hold);
endmodule

// File: rtl/lsr_err_track.sv
module lsr_err_track #(
    parameter int CNT_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push_err,
    input  logic pop_err,
    input  logic lsr_rd,
    output logic err_flag
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } err_st_t;

    err_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case ({push_err, pop_err})
            2'b10:   s_d.cnt = s_q.cnt + CNT_W'(1);
            2'b01:   s_d.cnt = s_q.cnt - CNT_W'(1);
            default: s_d.cnt = s_q.cnt;
        endcase
        s_d.flag = (s_d.cnt != '0) && !lsr_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign err_flag = s_q.flag;

    // R8: errored entries can only leave through a pop
    p_no_err_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop_err |-> (s_q.cnt != '0));
endmodule

// File: rtl/uart_lsr_core.sv
module uart_lsr_core
    import lsr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_char,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rx_brk,
    input  logic              rx_line,
    input  logic              rhr_pop,
    input  logic              lsr_rd,
    input  logic              thr_empty,
    input  logic              tsr_empty,
    output logic [7:0]        lsr,
    output logic [DATA_W-1:0] rhr_data
);
    localparam int CNT_W = $clog2(DEPTH+1);

    typedef struct packed {
        logic ovr;
    } top_st_t;

    top_st_t          s_d, s_q;
    logic             full;
    logic             push;
    logic             ovr_evt;
    logic             brk_hold;
    logic             pop_ok;
    logic             push_err;
    logic             pop_err;
    logic             err_flag;
    logic             dr;
    rx_ent_t          push_ent;
    rx_ent_t          top_ent;
    logic [CNT_W-1:0] count;

    always_comb begin
        full          = fifo_en ? (count == CNT_W'(DEPTH)) : (count != '0);
        push_ent.data = rx_brk ? '0 : rx_char;
        push_ent.perr = rx_perr;
        push_ent.ferr = rx_ferr;
        push_ent.brk  = rx_brk;
        push_err      = push && (rx_perr || rx_ferr || rx_brk);
        pop_err       = pop_ok && (top_ent.perr || top_ent.ferr || top_ent.brk);
        s_d           = s_q;
        if (ovr_evt)     s_d.ovr = 1'b1;
        else if (lsr_rd) s_d.ovr = 1'b0;
        dr            = (count != '0);
        lsr = {err_flag, thr_empty && tsr_empty, thr_empty,
               dr && top_ent.brk, dr && top_ent.ferr, dr && top_ent.perr,
               s_q.ovr, dr};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rhr_data = top_ent.data;

    lsr_push_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_done  (rx_done),
        .rx_brk   (rx_brk),
        .rx_line  (rx_line),
        .full     (full),
        .pop_ok   (pop_ok),
        .push     (push),
        .ovr_evt  (ovr_evt),
        .brk_hold (brk_hold)
    );

    lsr_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_ent (push_ent),
        .pop      (rhr_pop),
        .pop_ok   (pop_ok),
        .top_ent  (top_ent),
        .count    (count)
    );

    lsr_err_track #(.CNT_W(CNT_W)) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_err (push_err),
        .pop_err  (pop_err),
        .lsr_rd   (lsr_rd),
        .err_flag (err_flag)
    );

    // R2: completion into a full queue keeps the count and flags overrun
    p_ovr_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && rx_done && full && !pop_ok && !brk_hold)
        |=> (lsr[1] && count == $past(count)));

    // R3: single-register mode drops a second character
    p_single_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && count != '0 && rx_done && !pop_ok && !brk_hold)
        |=> (count == $past(count)));

    // R6: while holding after a break nothing is stored
    p_brk_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_hold && rx_done && !rhr_pop) |=> (count == $past(count)));

    // R7: an empty pair implies an empty holding stage
    p_temt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lsr[6] |-> lsr[5]);

    // R8: the summary bit stays set until a read or an errored pop
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr[7] && !lsr_rd && !pop_err) |=> lsr[7]);

    // R9: a pop of an empty queue leaves it empty
    p_pop_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && rhr_pop && !rx_done) |=> (count == '0));
endmodule

// File: tb/sim_uart_lsr_core.sv
module sim_uart_lsr_core;
    logic       clk = 1'b0;
    logic       rst_n, fifo_en, rx_done, rx_perr, rx_ferr, rx_brk, rx_line;
    logic       rhr_pop, lsr_rd, thr_empty, tsr_empty;
    logic [7:0] rx_char, lsr, rhr_data;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    bit  m_hold = 1'b0;

    typedef struct {
        logic [7:0] d;
        logic       p;
        logic       f;
        logic       b;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    uart_lsr_core u0 (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_done(rx_done),
        .rx_char(rx_char), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
        .rx_brk(rx_brk), .rx_line(rx_line), .rhr_pop(rhr_pop),
        .lsr_rd(lsr_rd), .thr_empty(thr_empty), .tsr_empty(tsr_empty),
        .lsr(lsr), .rhr_data(rhr_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: one completed character, the reference model fills the scoreboard
    task automatic send(input logic [7:0] d, input logic p, input logic f, input logic b);
        bit full_m;
        full_m = fifo_en ? (sb.size() == 16) : (sb.size() != 0);
        rx_char = d; rx_perr = p; rx_ferr = f; rx_brk = b; rx_done = 1'b1;
        @(negedge clk);
        rx_done = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
        if (!m_hold) begin
            if (!full_m) sb.push_back('{b ? 8'h00 : d, p, f, b});
            if (b) m_hold = 1'b1;
        end
    endtask

    // monitor: compare the oldest entry against the scoreboard, then pop it
    task automatic rd(input string req);
        exp_t e;
        if (sb.size() == 0) begin
            chk({req, " scoreboard empty"}, 1, 0);
        end else begin
            e = sb.pop_front();
            chk({req, " R9 data"}, rhr_data, e.d);
            chk("R5 tags", lsr[3:2], {e.f, e.p});
            chk("R6 break tag", lsr[4], e.b);
        end
        rhr_pop = 1'b1;
        @(negedge clk);
        rhr_pop = 1'b0;
    endtask

    task automatic read_lsr();
        lsr_rd = 1'b1;
        @(negedge clk);
        lsr_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; fifo_en = 1'b1; rx_done = 1'b0; rx_char = '0;
        rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0; rx_line = 1'b1;
        rhr_pop = 1'b0; lsr_rd = 1'b0; thr_empty = 1'b1; tsr_empty = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset word", lsr, 8'h60);

        // R7 transmit bits
        tsr_empty = 1'b0; @(negedge clk);
        chk("R7 holding empty only", lsr[6:5], 2'b01);
        thr_empty = 1'b0; @(negedge clk);
        chk("R7 both busy", lsr[6:5], 2'b00);
        thr_empty = 1'b1; tsr_empty = 1'b1; @(negedge clk);
        chk("R7 both empty", lsr[6:5], 2'b11);

        // R8 / R5 per-entry tags and summary bit
        send(8'hA1, 0, 0, 0);
        chk("R1 data ready", lsr[0], 1);
        send(8'hA2, 1, 0, 0);
        send(8'hA3, 0, 1, 0);
        chk("R8 summary set", lsr[7], 1);
        chk("R5 clean top", lsr[3:2], 2'b00);
        read_lsr();
        chk("R8 cleared by read", lsr[7], 0);
        @(negedge clk);
        chk("R8 sets again", lsr[7], 1);
        rd("R5 first");
        chk("R5 parity at top", lsr[2], 1);
        rd("R5 second");
        chk("R5 stop-bit at top", lsr[3], 1);
        chk("R8 still set", lsr[7], 1);
        rd("R5 third");
        chk("R8 cleared when drained", lsr, 8'h60);

        // R2 / R4 overrun in FIFO mode
        for (int i = 0; i < 16; i++) send(8'h10 + 8'(i), 0, 0, 0);
        chk("R2 no overrun when exactly full", lsr[1], 0);
        send(8'hEE, 0, 0, 0);
        chk("R2 overrun flagged", lsr[1], 1);
        read_lsr();
        chk("R4 overrun cleared", lsr[1], 0);
        rx_char = 8'hEF; rx_done = 1'b1; lsr_rd = 1'b1;
        @(negedge clk);
        rx_done = 1'b0; lsr_rd = 1'b0;
        chk("R4 set wins over read", lsr[1], 1);
        for (int i = 0; i < 16; i++) rd("R2 drain");
        chk("R2 dropped chars absent", lsr[0], 0);
        chk("R4 overrun sticky across pops", lsr[1], 1);
        read_lsr();
        chk("R4 cleared after drain", lsr[1], 0);

        // R6 break handling
        rx_line = 1'b0;
        send(8'h55, 0, 0, 1);
        send(8'h77, 0, 0, 0);
        chk("R6 single entry data", rhr_data, 8'h00);
        chk("R6 break bit", lsr[4], 1);
        chk("R6 ignored char no overrun", lsr[1], 0);
        rx_line = 1'b1; @(negedge clk); m_hold = 1'b0;
        send(8'h66, 0, 0, 0);
        rd("R6 break entry");
        rd("R6 after mark");
        chk("R6 exactly two entries", lsr[0], 0);
        read_lsr();

        // R9 pop on empty
        rhr_pop = 1'b1; @(negedge clk); rhr_pop = 1'b0;
        chk("R9 empty pop", lsr[0], 0);
        send(8'h44, 0, 0, 0);
        rd("R9 order kept");

        // R3 single holding register
        fifo_en = 1'b0; @(negedge clk);
        send(8'h31, 0, 0, 0);
        chk("R3 stored", lsr[0], 1);
        send(8'h32, 0, 0, 0);
        chk("R3 overrun", lsr[1], 1);
        rd("R3 old char kept");
        chk("R3 only one held", lsr[0], 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule